// File: doc/BRIEF.md
# Audio Subframe NRZ Serializer

This block turns decoded digital-audio channel words into a three-wire serial stream: a bit clock, a frame clock and one data line. All three outputs come from registers clocked by the master clock. Their rates come from a one-cycle enable pulse, `tick`, which must run at 256 times the sample rate. One frame is 256 ticks long and is split into a left slot and a right slot.

In the two NRZ formats each slot has 32 bit clocks. The first 28 data positions of the window carry 24 audio bits, least significant bit first, then the validity, user, channel-status and block-start flags. All other positions are low. In the biphase format the raw biphase input is sent to the data line with a faster bit clock.

The output is gated at slot boundaries. The data line stays low until the first frame-clock edge at which the error/lock flag is low, and it returns to low at the first frame-clock edge after the flag rises. The parallel words are captured at the start of each slot, so the source may update them at any point during the slot.

Top module: `nrz_audio_serializer`

## Requirements
- R1: `fmt_sel` = 3'b110 selects I2S-style NRZ timing, 3'b111 selects left-justified NRZ timing and 3'b101 selects biphase passthrough. Any other code holds the data line low while the clocks keep the left-justified shape.
- R2: In NRZ formats, data position d of a live slot (d counted from the first data position) carries audio bit d for d = 0..23. Position 24 carries V (bit 0 of the channel's `*_vuc` bus), 25 carries U (bit 1), 26 carries C (bit 2) and 27 carries the block-start flag.
- R3: Every bit-clock position of a slot outside the 28-position window is low: positions 28..31 in left-justified format, and positions 0 and 29..31 in I2S format.
- R4: In I2S format the left slot is sent while the frame clock is low, and data position 0 falls on the second bit clock after the frame-clock transition. In left-justified format the left slot is sent while the frame clock is high, and data position 0 falls on the first bit clock.
- R5: In NRZ formats the bit clock has a period of 4 ticks, giving 64 bit clocks per frame. The data line and the frame clock change only on the cycle in which the bit clock falls.
- R6: At every slot boundary the block samples `err`. A slot that starts with `err` low is live. A slot that starts with `err` high keeps the data line low for the whole slot, in every format.
- R7: Each channel's audio word and flags are captured at the start of that channel's slot. Changes to the inputs during a slot do not affect the bits being sent.
- R8: `blk_start` is captured at the start of the left slot. The same value is sent as the block-start bit in both the left and right slots of that frame.
- R9: In biphase format a live data line repeats `bp_in` one master-clock cycle later. The bit clock toggles on every tick while `err` is low and on every second tick while `err` is high.
- R10: During reset all three outputs are low. Each output change appears one master-clock cycle after the tick that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Phase enable pulse, 256 per frame |
| fmt_sel | input | 3 | Output format code |
| err | input | 1 | Error / lock-lost flag, high means not locked |
| l_aud | input | AUD_W | Left audio word |
| l_vuc | input | 3 | Left flags: bit 0 V, bit 1 U, bit 2 C |
| r_aud | input | AUD_W | Right audio word |
| r_vuc | input | 3 | Right flags: bit 0 V, bit 1 U, bit 2 C |
| blk_start | input | 1 | Block-start preamble seen in the current frame |
| bp_in | input | 1 | Raw biphase stream |
| bclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Frame clock |
| dout_o | output | 1 | Serial data |

## Verification
The bench starts the stream with `err` high and then releases it in mid-slot. A gate that opened at once, rather than at the next boundary, would produce a partial slot that fails the comparison. It raises `err` in the middle of a live slot and expects that slot to finish whole. It also rewrites every input word right after each boundary, so a serializer that reads the inputs directly instead of a captured copy would send mixed bits. Each slot is compared across all 32 positions in both NRZ formats. This catches an I2S delay that was dropped or doubled, a swapped frame-clock polarity, a flag placed at the wrong position, a block-start bit lost on the right slot, and any stray high bit outside the window. Biphase mode is checked for the one-cycle passthrough delay and for the bit-clock period both locked and unlocked.

// File: rtl/nrz_ser_pkg.sv
// Shared definitions for the audio subframe NRZ serializer.
// Assumes format codes are decoded exactly; all other codes mean "data off".
package nrz_ser_pkg;
    typedef enum logic [2:0] {
        FMT_BIPHASE = 3'b101,
        FMT_I2S     = 3'b110,
        FMT_LJ      = 3'b111
    } fmt_e;
endpackage

// File: rtl/nser_timebase.sv
// Phase counter for one frame. It advances on each tick; the low bits
// give the bit-clock phase, the middle bits the bit position in a slot,
// and the top bit the slot half.
// Assumes tick is a single-cycle pulse at 256 x fs.
module nser_timebase #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             bnd
);
    // Step the frame phase once per enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    // Strobe for the edge at which the counter enters a new slot.
    assign bnd = tick && (&cnt[CNT_W-2:0]);

    // R10: the phase holds between ticks
    p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
endmodule

// File: rtl/nser_slot.sv
// Slot engine. At each slot boundary it captures the next channel's word
// and samples the error flag to decide whether that slot is live. It then
// selects the data bit for the current bit position, applying the I2S
// one-bit delay when asked.
// Assumes VALID + 1 <= SLOT_BITS, so the delayed window fits in a slot.
module nser_slot #(
    parameter int AUD_W     = 24,
    parameter int SLOT_BITS = 32,
    localparam int VALID    = AUD_W + 4,
    localparam int POS_W    = $clog2(SLOT_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bnd,
    input  logic             to_right,
    input  logic             err,
    input  logic             i2s,
    input  logic [POS_W-1:0] bitpos,
    input  logic [VALID-2:0] l_word,
    input  logic [VALID-2:0] r_word,
    input  logic             blk_start,
    output logic             live,
    output logic             bit_o
);
    logic [VALID-1:0]     shadow;
    logic                 blk_q;
    logic [SLOT_BITS-1:0] padded;
    logic [POS_W-1:0]     idx;

    // Capture the word, the block flag and the live decision at slot start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            blk_q  <= 1'b0;
            live   <= 1'b0;
        end else if (bnd) begin
            live <= !err;
            if (!to_right) begin
                shadow <= {blk_start, l_word};
                blk_q  <= blk_start;
            end else begin
                shadow <= {blk_q, r_word};
            end
        end
    end

    // Pick the bit for this position; zero padding covers positions outside the window.
    always_comb begin
        padded = {{(SLOT_BITS-VALID){1'b0}}, shadow};
        idx    = i2s ? bitpos - POS_W'(1) : bitpos;
        bit_o  = live & padded[idx];
    end

    // R7: the captured word changes only at a slot boundary
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd |=> $stable(shadow));
    // R6: the live decision changes only at a slot boundary
    p_live_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd |=> $stable(live));
endmodule

// File: rtl/nrz_audio_serializer.sv
// Top of the audio subframe serializer. It decodes the format code,
// builds the bit clock and frame clock from the phase counter, chooses
// between the NRZ slot bit and the biphase input, and registers all three
// outputs on the master clock.
// Assumes tick runs at 256 x fs and err is synchronous to clk.
module nrz_audio_serializer #(
    parameter int AUD_W     = 24,
    parameter int SLOT_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [2:0]       fmt_sel,
    input  logic             err,
    input  logic [AUD_W-1:0] l_aud,
    input  logic [2:0]       l_vuc,
    input  logic [AUD_W-1:0] r_aud,
    input  logic [2:0]       r_vuc,
    input  logic             blk_start,
    input  logic             bp_in,
    output logic             bclk_o,
    output logic             lrck_o,
    output logic             dout_o
);
    localparam int POS_W    = $clog2(SLOT_BITS);
    localparam int TICK_LOG = 2;
    localparam int CNT_W    = POS_W + 1 + TICK_LOG;

    logic [CNT_W-1:0] cnt;
    logic             bnd, live, slot_bit;
    logic             is_i2s, is_lj, is_bp, is_nrz, half;
    logic             bclk_n, lrck_n, dout_n;
    logic [2:0]       fmt_q;

    nser_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .bnd(bnd)
    );

    nser_slot #(.AUD_W(AUD_W), .SLOT_BITS(SLOT_BITS)) u_slot (
        .clk(clk), .rst_n(rst_n), .bnd(bnd),
        .to_right(!cnt[CNT_W-1]), .err(err), .i2s(is_i2s),
        .bitpos(cnt[CNT_W-2:TICK_LOG]),
        .l_word({l_vuc, l_aud}), .r_word({r_vuc, r_aud}),
        .blk_start(blk_start), .live(live), .bit_o(slot_bit)
    );

    // Decode the format and form the next clock and data levels.
    always_comb begin
        is_i2s = (fmt_sel == nrz_ser_pkg::FMT_I2S);
        is_lj  = (fmt_sel == nrz_ser_pkg::FMT_LJ);
        is_bp  = (fmt_sel == nrz_ser_pkg::FMT_BIPHASE);
        is_nrz = is_i2s | is_lj;
        half   = cnt[CNT_W-1];
        bclk_n = (is_bp && !err) ? cnt[TICK_LOG-2] : cnt[TICK_LOG-1];
        lrck_n = is_i2s ? half : !half;
        if (is_bp)       dout_n = live & bp_in;
        else if (is_nrz) dout_n = slot_bit;
        else             dout_n = 1'b0;
    end

    // Register the three output wires and the format seen on this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_o <= 1'b0;
            lrck_o <= 1'b0;
            dout_o <= 1'b0;
            fmt_q  <= 3'b000;
        end else begin
            bclk_o <= bclk_n;
            lrck_o <= lrck_n;
            dout_o <= dout_n;
            fmt_q  <= fmt_sel;
        end
    end

    // R5: in a steady NRZ format the data line moves only with a falling bit clock
    p_data_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q[2] && fmt_q[1] && $stable(fmt_q) && !$stable(dout_o)) |-> $fell(bclk_o));
    // R5: in a steady NRZ format the frame clock moves only with a falling bit clock
    p_lrck_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q[2] && fmt_q[1] && $stable(fmt_q) && !$stable(lrck_o)) |-> $fell(bclk_o));
    // R6: a slot that is not live drives no data
    p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !live |=> !dout_o);
endmodule

// File: tb/test_nrz_audio_serializer.sv
module test_nrz_audio_serializer;
    logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic [2:0]  fmt_sel = 3'b110;
    logic        err = 1'b1, blk_start = 1'b0, bp_in = 1'b0;
    logic [23:0] l_aud = '0, r_aud = '0;
    logic [2:0]  l_vuc = '0, r_vuc = '0;
    logic        bclk_o, lrck_o, dout_o;

    typedef struct {
        logic [31:0] pat;
        logic        lvl;
        string       tag;
    } item_t;
    item_t sb[$];

    int n_cmp = 0, n_bad = 0;
    bit nrz_on = 0;

    nrz_audio_serializer i_nrz_audio_serializer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fmt_sel(fmt_sel), .err(err),
        .l_aud(l_aud), .l_vuc(l_vuc), .r_aud(r_aud), .r_vuc(r_vuc),
        .blk_start(blk_start), .bp_in(bp_in),
        .bclk_o(bclk_o), .lrck_o(lrck_o), .dout_o(dout_o)
    );

    always #2 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            tick = rst_n ? ~tick : 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_edge();
        logic p;
        p = lrck_o;
        do @(negedge clk); while (lrck_o == p);
        repeat (3) @(negedge clk);
    endtask

    // Driver: right after a slot starts, load new inputs and predict the next slot.
    task automatic drive_slot(input bit e, input string tag);
        item_t it;
        logic nl;
        bit left;
        logic [27:0] w;
        wait_edge();
        nl = ~lrck_o;
        left = (fmt_sel == 3'b110) ? (nl == 1'b0) : (nl == 1'b1);
        err = e;
        l_aud = 24'($urandom); l_vuc = 3'($urandom);
        r_aud = 24'($urandom); r_vuc = 3'($urandom);
        if (left) blk_start = 1'($urandom);
        w = left ? {blk_start, l_vuc, l_aud} : {blk_start, r_vuc, r_aud};
        if (e) it.pat = '0;
        else if (fmt_sel == 3'b110) it.pat = {3'b000, w, 1'b0};
        else it.pat = {4'b0000, w};
        it.lvl = nl;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic bclk_period(output int n);
        logic p;
        do begin p = bclk_o; @(negedge clk); end while (!(bclk_o && !p));
        n = 0;
        do begin p = bclk_o; @(negedge clk); n++; end while (!(bclk_o && !p));
    endtask

    // Monitor: collect 32 bit-clock samples per slot and compare with the queue.
    initial begin
        logic pl, pb, lvl;
        logic [31:0] got;
        int idx;
        bit coll;
        item_t e;
        pl = 1'b0; pb = 1'b0; coll = 0; idx = 0; got = '0; lvl = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n || !nrz_on) begin
                coll = 0;
            end else begin
                if (lrck_o != pl) begin
                    coll = (sb.size() > 0);
                    idx = 0; got = '0; lvl = lrck_o;
                end
                if (coll && bclk_o && !pb) begin
                    got[idx] = dout_o;
                    idx++;
                    if (idx == 32) begin
                        e = sb.pop_front();
                        check(got == e.pat && lvl == e.lvl, e.tag,
                              {lvl, got}, {e.lvl, e.pat});
                        coll = 0;
                    end
                end
            end
            pl = lrck_o;
            pb = bclk_o;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int per;
        bit quiet;
        int edges;
        logic p;
        repeat (5) @(negedge clk);
        // R10: reset state of the outputs
        check(bclk_o == 1'b0, "R10 bclk in reset", bclk_o, 0);
        check(lrck_o == 1'b0, "R10 lrck in reset", lrck_o, 0);
        check(dout_o == 1'b0, "R10 dout in reset", dout_o, 0);
        rst_n = 1'b1;
        nrz_on = 1;

        // I2S: hold-off, live stream, mid-slot error, restart (R2 R3 R4 R6 R7 R8)
        repeat (3) drive_slot(1'b1, "R6 hold-off i2s");
        repeat (10) drive_slot(1'b0, "R2 R3 R4 R7 R8 i2s slot");
        repeat (2) drive_slot(1'b1, "R6 stop i2s");
        repeat (5) drive_slot(1'b0, "R2 R4 R8 i2s restart");
        wait_edge(); wait_edge();
        check(sb.size() == 0, "R6 i2s queue drained", sb.size(), 0);

        bclk_period(per);
        check(per == 8, "R5 nrz bit clock period", per, 8);

        // Left-justified (R1 R2 R3 R4 R6 R8)
        nrz_on = 0; sb.delete();
        fmt_sel = 3'b111;
        wait_edge(); wait_edge();
        nrz_on = 1;
        repeat (8) drive_slot(1'b0, "R1 R2 R3 R4 R8 lj slot");
        drive_slot(1'b1, "R6 stop lj");
        repeat (5) drive_slot(1'b0, "R2 R6 lj restart");
        wait_edge(); wait_edge();
        check(sb.size() == 0, "R6 lj queue drained", sb.size(), 0);
        nrz_on = 0;

        // R1: an unused code keeps the data low while the frame clock runs
        fmt_sel = 3'b000; err = 1'b0;
        l_aud = '1; r_aud = '1; l_vuc = '1; r_vuc = '1;
        quiet = 1; edges = 0; p = lrck_o;
        repeat (600) begin
            @(negedge clk);
            if (dout_o) quiet = 0;
            if (lrck_o != p) edges++;
            p = lrck_o;
        end
        check(quiet, "R1 unused code data low", !quiet, 0);
        check(edges >= 2, "R1 unused code frame clock", edges, 2);

        // R9: biphase passthrough and bit clock rates
        fmt_sel = 3'b101; err = 1'b0;
        wait_edge(); wait_edge();
        for (int i = 0; i < 40; i++) begin
            logic prev;
            prev = 1'($urandom);
            bp_in = prev;
            @(negedge clk);
            check(dout_o == prev, "R9 biphase passthrough", dout_o, prev);
        end
        bclk_period(per);
        check(per == 4, "R9 biphase locked bit clock", per, 4);
        err = 1'b1;
        repeat (3) @(negedge clk);
        bclk_period(per);
        check(per == 8, "R9 biphase unlocked bit clock", per, 8);
        wait_edge();
        quiet = 1;
        repeat (40) begin
            bp_in = ~bp_in;
            @(negedge clk);
            if (dout_o) quiet = 0;
        end
        check(quiet, "R6 biphase gated off by error", !quiet, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule